// File: doc/BRIEF.md
# Per-Lane Event Counter Bank

This block holds a bank of event counters for the debug space of a link controller. There is one counter for every event number of two counting groups on every lane. Each counter has its own one-cycle event strobe input. Software reaches the bank through two registers: a control word and a data word. A single write to the control word selects which counter is visible, by group, event number and lane. The same write can also start, stop or zero that counter through small coded sub-fields. The data word then returns the count of the selected counter.

Counters run independently of the selection. A counter that has been started keeps counting after software moves its view to another counter. Stopping a counter keeps its value. The only way to zero a counter is an explicit clear code. A selection that names a group outside the two counting groups, or an event number or lane that is not built, has no counter behind it: it reads as zero and its commands do nothing.

The register port carries no stream traffic, so it uses no valid/ready handshake. It is always ready. A write takes effect at the clock edge where `reg_wr_en` is high. Read data is combinational on `reg_addr` and the current state.

Top module: `lane_evt_counter_bank`

## Requirements
- R1: After reset every counter is zero and stopped, the selection is group 0, event 0, lane 0, and both registers read zero.
- R2: A write to the control word at offset 0x8 loads the selection. The group is in bits 27:24, the event number in bits 23:16 and the lane in bits 11:8. Reading the control word returns these fields and the status bit 7, with bits 4:0 reading zero. The selection changes only on a control-word write.
- R3: Enable code 3 in control bits 4:2 starts the selected counter and code 1 stops it. A stopped counter holds its value, and a restarted counter continues from that value.
- R4: A started counter adds one at every clock edge where its strobe is high. The strobe for group g (6 or 7), event e and lane l is bit ((g-6)*NUM_EVENTS+e)*NUM_LANES+l of `evt_strobe`. Counters count whether or not they are selected.
- R5: Clear code 1 in control bits 1:0 zeroes only the selected counter. Clear codes 0, 2 and 3 leave it unchanged.
- R6: Enable codes 0, 2, 4, 5, 6 and 7 leave the run state of the selected counter unchanged, so such a write only moves the selection.
- R7: Status bit 7 of the control word reads 1 exactly while the selected counter is started.
- R8: Counters wrap modulo 2^CNT_W (CNT_W is 32 by default).
- R9: When a clear and a strobe reach the same counter at the same edge, the counter becomes zero.
- R10: A selection with a group other than 6 or 7, an event number of NUM_EVENTS or more, or a lane of NUM_LANES or more reads zero data and zero status. Its enable and clear codes change no counter.
- R11: The data word at offset 0xC returns the selected count, zero-extended to 32 bits. Writes to it change nothing, and any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 2*NUM_EVENTS*NUM_LANES | One strobe per counter, indexed as in R4 |
| reg_wr_en | input | 1 | Register write at this edge |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
Counting is tried with bursts of strobes on a started counter, on a stopped one and on a counter that is not selected. This separates per-counter run state from the selection, and shows that a stop keeps the value. Clears are sent with each clear code, on a counter next to another running counter, and in the same cycle as a strobe. This shows that only code 1 acts, that it acts only on its target, and that it has priority over the strobe. Out-of-range selections are chosen so that a naive index would land on a live counter, which exposes any command that leaks through. A narrow-counter instance shows the wrap.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int WORD_W   = 32;
  localparam int OFF_CTRL = 8;
  localparam int OFF_DATA = 12;

  localparam int GRP_LO   = 24;
  localparam int EVN_LO   = 16;
  localparam int LANE_LO  = 8;
  localparam int STAT_BIT = 7;
  localparam int EN_LO    = 2;
  localparam int CLR_LO   = 0;

  localparam logic [3:0] GRP_BASE      = 4'd6;
  localparam logic [3:0] GRP_TOP       = 4'd7;
  localparam logic [2:0] EN_CODE_STOP  = 3'd1;
  localparam logic [2:0] EN_CODE_START = 3'd3;
  localparam logic [1:0] CLR_CODE_ZERO = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evn;
    logic [3:0] lane;
  } sel_t;
endpackage

// File: rtl/lec_sel_decode.sv
module lec_sel_decode
  import lec_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int NUM_EVENTS = 4,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  cmd_idx,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_clear,
  output sel_t              sel_q,
  output logic              sel_valid_q,
  output logic [IDX_W-1:0]  sel_idx_q
);
  sel_t       nxt_sel;
  logic       nxt_valid;
  logic [2:0] en_code;
  logic [1:0] clr_code;

  function automatic logic in_range(sel_t s);
    return ((s.grp == GRP_BASE) || (s.grp == GRP_TOP)) &&
           (int'(s.evn) < NUM_EVENTS) && (int'(s.lane) < NUM_LANES);
  endfunction

  function automatic logic [IDX_W-1:0] flat_index(sel_t s);
    int v;
    v = ((int'(s.grp) - int'(GRP_BASE)) * NUM_EVENTS + int'(s.evn)) * NUM_LANES
        + int'(s.lane);
    return IDX_W'(v);
  endfunction

  assign nxt_sel.grp  = wdata[GRP_LO +: 4];
  assign nxt_sel.evn  = wdata[EVN_LO +: 8];
  assign nxt_sel.lane = wdata[LANE_LO +: 4];
  assign en_code      = wdata[EN_LO +: 3];
  assign clr_code     = wdata[CLR_LO +: 2];
  assign nxt_valid    = in_range(nxt_sel);

  assign cmd_idx   = nxt_valid ? flat_index(nxt_sel) : '0;
  assign cmd_start = wr_ctrl && nxt_valid && (en_code == EN_CODE_START);
  assign cmd_stop  = wr_ctrl && nxt_valid && (en_code == EN_CODE_STOP);
  assign cmd_clear = wr_ctrl && nxt_valid && (clr_code == CLR_CODE_ZERO);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
    end else if (wr_ctrl) begin
      sel_q       <= nxt_sel;
      sel_valid_q <= nxt_valid;
      sel_idx_q   <= cmd_idx;
    end
  end

  // R2: selection moves only on a control write
  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(sel_q) && $stable(sel_idx_q));

  // R10: commands never issue for an out-of-range selection
  assert_invalid_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !in_range(nxt_sel)) |-> !(cmd_start || cmd_stop || cmd_clear));
endmodule

// File: rtl/lec_counter_cell.sv
module lec_counter_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             do_start,
  input  logic             do_stop,
  input  logic             do_clear,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (do_start)     run_q <= 1'b1;
      else if (do_stop) run_q <= 1'b0;
      if (do_clear)                cnt_q <= '0;
      else if (run_q && strobe)    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: clear has priority over a simultaneous strobe
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> cnt_q == '0);

  // R3: a stopped counter holds its value
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !do_clear) |=> cnt_q == $past(cnt_q));

  // R4: a running counter steps by one on a strobe
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && strobe && !do_clear) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R8: without a clear the count only holds or steps by one (modular)
  assert_no_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_clear |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lec_readback.sv
module lec_readback
  import lec_pkg::*;
#(
  parameter int NCNT  = 32,
  parameter int CNT_W = 32,
  parameter int IDX_W = 5
) (
  input  logic                  rd_ctrl,
  input  logic                  rd_data,
  input  sel_t                  sel,
  input  logic                  sel_valid,
  input  logic [IDX_W-1:0]      sel_idx,
  input  logic [NCNT*CNT_W-1:0] cnt_flat,
  input  logic [NCNT-1:0]       run_vec,
  output logic [WORD_W-1:0]     rdata
);
  logic [CNT_W-1:0] sel_cnt;
  logic             status;

  assign sel_cnt = cnt_flat[int'(sel_idx)*CNT_W +: CNT_W];
  assign status  = sel_valid && run_vec[sel_idx];

  always_comb begin
    rdata = '0;
    if (rd_ctrl) begin
      rdata[GRP_LO +: 4]  = sel.grp;
      rdata[EVN_LO +: 8]  = sel.evn;
      rdata[LANE_LO +: 4] = sel.lane;
      rdata[STAT_BIT]     = status;
    end else if (rd_data && sel_valid) begin
      rdata = WORD_W'(sel_cnt);
    end
  end
endmodule

// File: rtl/lane_evt_counter_bank.sv
module lane_evt_counter_bank
  import lec_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int NUM_EVENTS = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2*NUM_EVENTS*NUM_LANES-1:0] evt_strobe,
  input  logic                              reg_wr_en,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata
);
  localparam int NCNT  = 2 * NUM_EVENTS * NUM_LANES;
  localparam int IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

  logic             wr_ctrl;
  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_start, cmd_stop, cmd_clear;
  sel_t             sel_q;
  logic             sel_valid_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic [NCNT*CNT_W-1:0] cnt_flat;
  logic [NCNT-1:0]       run_vec;

  assign wr_ctrl = reg_wr_en && (reg_addr == A_CTRL);

  lec_sel_decode #(
    .NUM_LANES(NUM_LANES), .NUM_EVENTS(NUM_EVENTS), .IDX_W(IDX_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .cmd_idx(cmd_idx), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .sel_q(sel_q), .sel_valid_q(sel_valid_q),
    .sel_idx_q(sel_idx_q)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cell
    logic hit;
    assign hit = (cmd_idx == IDX_W'(i));
    lec_counter_cell #(.CNT_W(CNT_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .strobe(evt_strobe[i]),
      .do_start(hit && cmd_start), .do_stop(hit && cmd_stop),
      .do_clear(hit && cmd_clear),
      .run_q(run_vec[i]), .cnt_q(cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  lec_readback #(.NCNT(NCNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .rd_ctrl(reg_addr == A_CTRL), .rd_data(reg_addr == A_DATA),
    .sel(sel_q), .sel_valid(sel_valid_q), .sel_idx(sel_idx_q),
    .cnt_flat(cnt_flat), .run_vec(run_vec), .rdata(reg_rdata)
  );

  // R10: an out-of-range selection reads zero data
  assert_invalid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_DATA && !sel_valid_q) |-> reg_rdata == '0);

  // R11: unmapped offsets read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_DATA && reg_addr != A_CTRL) |-> reg_rdata == '0);
endmodule

// File: tb/lane_evt_counter_bank_tb.sv
module lane_evt_counter_bank_tb_top;
  localparam int NL = 4;
  localparam int NE = 4;
  localparam logic [7:0] CTRL = 8'h08;
  localparam logic [7:0] DATA = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strobe = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  logic        w_wr_en = 1'b0;
  logic [7:0]  w_addr = '0;
  logic [31:0] w_wdata = '0;
  logic [1:0]  w_strobe = '0;
  logic [31:0] w_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_evt_counter_bank #(.NUM_LANES(NL), .NUM_EVENTS(NE), .CNT_W(32), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_strobe(strobe), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata));

  lane_evt_counter_bank #(.NUM_LANES(1), .NUM_EVENTS(1), .CNT_W(8), .ADDR_W(8)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .evt_strobe(w_strobe), .reg_wr_en(w_wr_en),
    .reg_addr(w_addr), .reg_wdata(w_wdata), .reg_rdata(w_rdata));

  function automatic logic [31:0] cw(int g, int e, int l, int en, int clr);
    logic [31:0] w;
    w = '0;
    w[27:24] = 4'(g); w[23:16] = 8'(e); w[11:8] = 4'(l);
    w[4:2] = 3'(en); w[1:0] = 2'(clr);
    return w;
  endfunction

  function automatic int sidx(int g, int e, int l);
    return ((g - 6) * NE + e) * NL + l;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic pulse(int idx, int n);
    repeat (n) begin @(negedge clk); strobe[idx] = 1'b1; end
    @(negedge clk); strobe[idx] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTRL, v); check("R1 ctrl after reset", v, 32'h0);
    rd(DATA, v); check("R1 data after reset", v, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(CTRL, cw(7, 2, 3, 0, 0));
    rd(CTRL, v); check("R2 selection readback", v, 32'h0702_0300);
    rd(8'h10, v); check("R11 unmapped offset", v, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(CTRL, cw(6, 1, 2, 3, 0));
    pulse(sidx(6, 1, 2), 5);
    rd(DATA, v); check("R4 five strobes", v, 32'd5);
    rd(CTRL, v); check("R7 status running", {31'b0, v[7]}, 32'd1);
    wr(CTRL, cw(6, 1, 2, 1, 0));
    rd(CTRL, v); check("R7 status stopped", {31'b0, v[7]}, 32'd0);
    pulse(sidx(6, 1, 2), 3);
    rd(DATA, v); check("R3 stopped holds", v, 32'd5);
    wr(CTRL, cw(6, 1, 2, 3, 0));
    pulse(sidx(6, 1, 2), 2);
    rd(DATA, v); check("R3 resume from held value", v, 32'd7);
  endtask

  task automatic t_selection_only;
    logic [31:0] v;
    wr(CTRL, cw(7, 0, 1, 0, 0));
    pulse(sidx(7, 0, 1), 4);
    pulse(sidx(6, 1, 2), 3);
    rd(DATA, v); check("R4 unstarted counter stays zero", v, 32'd0);
    wr(CTRL, cw(6, 1, 2, 2, 0));
    rd(CTRL, v); check("R6 code 2 keeps running", {31'b0, v[7]}, 32'd1);
    rd(DATA, v); check("R4 unselected counter kept counting", v, 32'd10);
    wr(CTRL, cw(6, 1, 2, 5, 0));
    rd(CTRL, v); check("R6 code 5 keeps running", {31'b0, v[7]}, 32'd1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(CTRL, cw(7, 3, 0, 3, 0));
    pulse(sidx(7, 3, 0), 4);
    wr(CTRL, cw(6, 1, 2, 0, 2));
    rd(DATA, v); check("R5 clear code 2 ignored", v, 32'd10);
    wr(CTRL, cw(6, 1, 2, 0, 3));
    rd(DATA, v); check("R5 clear code 3 ignored", v, 32'd10);
    wr(CTRL, cw(6, 1, 2, 0, 1));
    rd(DATA, v); check("R5 clear code 1 zeroes", v, 32'd0);
    wr(CTRL, cw(7, 3, 0, 0, 0));
    rd(DATA, v); check("R5 neighbour untouched", v, 32'd4);
  endtask

  task automatic t_clear_wins;
    logic [31:0] v;
    wr(CTRL, cw(6, 0, 0, 3, 0));
    pulse(sidx(6, 0, 0), 3);
    @(negedge clk); strobe[sidx(6, 0, 0)] = 1'b1;
    wr_en = 1'b1; addr = CTRL; wdata = cw(6, 0, 0, 0, 1);
    @(negedge clk); strobe[sidx(6, 0, 0)] = 1'b0; wr_en = 1'b0;
    rd(DATA, v); check("R9 clear beats strobe", v, 32'd0);
  endtask

  task automatic t_invalid;
    logic [31:0] v;
    wr(CTRL, cw(6, 1, 0, 3, 0));
    pulse(sidx(6, 1, 0), 6);
    wr(CTRL, cw(6, 0, 4, 1, 1));
    rd(DATA, v); check("R10 lane out of range reads zero", v, 32'd0);
    rd(CTRL, v); check("R10 invalid status zero", {31'b0, v[7]}, 32'd0);
    wr(CTRL, cw(5, 1, 0, 1, 1));
    rd(DATA, v); check("R10 group 5 reads zero", v, 32'd0);
    wr(CTRL, cw(6, 4, 0, 0, 0));
    rd(DATA, v); check("R10 event out of range reads zero", v, 32'd0);
    wr(CTRL, cw(6, 1, 0, 0, 0));
    rd(DATA, v); check("R10 invalid commands no effect", v, 32'd6);
    rd(CTRL, v); check("R10 run state kept", {31'b0, v[7]}, 32'd1);
    wr(DATA, 32'h0);
    rd(DATA, v); check("R11 data write ignored", v, 32'd6);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    @(negedge clk); w_wr_en = 1'b1; w_addr = CTRL; w_wdata = cw(6, 0, 0, 3, 0);
    @(negedge clk); w_wr_en = 1'b0; w_addr = DATA;
    repeat (255) begin @(negedge clk); w_strobe[0] = 1'b1; end
    @(negedge clk); w_strobe[0] = 1'b0; #1;
    check("R8 narrow counter at 255", w_rdata, 32'd255);
    repeat (3) begin @(negedge clk); w_strobe[0] = 1'b1; end
    @(negedge clk); w_strobe[0] = 1'b0; #1;
    check("R8 wraps to 2", w_rdata, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_count();
    t_selection_only();
    t_clear();
    t_clear_wins();
    t_invalid();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule